// File: doc/BRIEF.md
# Data Pointer and Nibble RAM Exchange Unit

This block owns the data-side storage of a small 4-bit controller: an 8-bit data pointer split into a high nibble and a low nibble, a 256-word by 4-bit data RAM addressed by that pointer, four accumulator scratch registers, and two spare registers for each pointer nibble. Each clock cycle the controller presents one operation code, a 4-bit immediate and the current accumulator. The block answers in the same cycle with the accumulator value the controller should keep, the zero flag value, and a strobe that says whether the zero flag is to be updated. Its own state then changes at the next rising clock edge.

The exchange operations swap the accumulator with the RAM word under the pointer and then adjust the pointer. The low nibble can step up or down by one, or the high nibble can be XORed with a 3-bit immediate. For those operations the zero flag reports the adjusted pointer nibble and not the data. This lets a loop that walks a RAM row end when the low nibble wraps to zero.

Top module: `dpx_unit`

## Requirements
- R1: After reset the pointer high nibble, pointer low nibble, the four scratch registers and the four spare pointer registers read as zero. RAM contents are not reset.
- R2: Load (op 1) returns the RAM word at {high, low} as the new accumulator and updates ZF (set when that word is zero). Store (op 2) writes the accumulator into that word, leaves the accumulator unchanged and does not update ZF.
- R3: Plain exchange (op 3) returns the old RAM word as the new accumulator and writes the old accumulator into the word. ZF is updated from the new accumulator.
- R4: Exchange-up (op 4) swaps as in R3 and then adds 1 to the low nibble. ZF is updated from the new low nibble.
- R5: Exchange-down (op 5) swaps as in R3 and then subtracts 1 from the low nibble. ZF is updated from the new low nibble.
- R6: Exchange-flip (op 6) swaps as in R3 and then XORs the high nibble with {0, imm[2:0]}. Immediate bit 3 has no effect. ZF is updated from the new high nibble.
- R7: Zero-load (op 7) sets the high nibble to 0 and the low nibble to imm. High-load (op 8) sets only the high nibble to imm. Neither changes the accumulator or updates ZF.
- R8: Step-up (op 9) and step-down (op 10) change the low nibble by ±1 modulo 16 without carry or borrow into the high nibble. ZF is updated from the new low nibble.
- R9: Accumulator-to-low (op 11) copies the accumulator into the low nibble and does not update ZF. Low-to-accumulator (op 12) returns the low nibble as the accumulator and updates ZF.
- R10: Scratch exchange (op 13) swaps the accumulator with scratch register imm[1:0]. ZF is not updated.
- R11: High swap (op 14) exchanges the high nibble with spare H register imm[0]. Low swap (op 15) exchanges the low nibble with spare L register imm[0]. The accumulator is unchanged and ZF is not updated.
- R12: Idle (op 0) changes no state, returns the accumulator unchanged and does not update ZF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code (0..15, see requirements) |
| imm_i | input | 4 | Immediate nibble |
| acc_i | input | 4 | Current accumulator |
| acc_o | output | 4 | Accumulator value to keep after the operation |
| zf_o | output | 1 | Zero flag value for this operation |
| zf_we_o | output | 1 | High when the operation updates the zero flag |

## Verification
The embedded assertions check pointer arithmetic on every cycle. They cover the ±1 wrap of the low nibble with the high nibble held steady, the 3-bit XOR on the high nibble, the immediate loads, and that the scratch registers hold when no scratch exchange is issued. Only the bench scenarios can show that an exchange really stores the old accumulator: a later load at the same address has to bring that value back. The same holds for a step-down from zero, which must not disturb the row used by the next access. Spare-register swaps and the flag source for each operation are also visible only through the sequences the bench applies.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'h0,
    OP_LD   = 4'h1,
    OP_ST   = 4'h2,
    OP_XCH  = 4'h3,
    OP_XCHI = 4'h4,
    OP_XCHD = 4'h5,
    OP_XCHM = 4'h6,
    OP_LDZ  = 4'h7,
    OP_LHI  = 4'h8,
    OP_INCL = 4'h9,
    OP_DECL = 4'hA,
    OP_TAL  = 4'hB,
    OP_TLA  = 4'hC,
    OP_XAW  = 4'hD,
    OP_XHP  = 4'hE,
    OP_XLP  = 4'hF
  } op_e;
endpackage

// File: rtl/dpx_ptr.sv
module dpx_ptr
  import dpx_pkg::*;
#(
  parameter int NW    = 4,
  parameter int NPAIR = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op,
  input  logic [NW-1:0] imm,
  input  logic [NW-1:0] acc,
  output logic [NW-1:0] dph_q,
  output logic [NW-1:0] dpl_q,
  output logic [NW-1:0] dph_d,
  output logic [NW-1:0] dpl_d
);
  localparam int SW = (NPAIR > 1) ? $clog2(NPAIR) : 1;

  logic [NPAIR-1:0][NW-1:0] hp_q, hp_d, lp_q, lp_d;
  logic [SW-1:0]            sel;
  logic                     en;

  assign sel = imm[SW-1:0];

  always_comb begin
    dph_d = dph_q;
    dpl_d = dpl_q;
    hp_d  = hp_q;
    lp_d  = lp_q;
    en    = 1'b1;
    unique case (op)
      OP_LDZ:           begin dph_d = '0; dpl_d = imm; end
      OP_LHI:           dph_d = imm;
      OP_INCL, OP_XCHI: dpl_d = dpl_q + 1'b1;
      OP_DECL, OP_XCHD: dpl_d = dpl_q - 1'b1;
      OP_XCHM:          dph_d = dph_q ^ {1'b0, imm[NW-2:0]};
      OP_TAL:           dpl_d = acc;
      OP_XHP:           begin dph_d = hp_q[sel]; hp_d[sel] = dph_q; end
      OP_XLP:           begin dpl_d = lp_q[sel]; lp_d[sel] = dpl_q; end
      default:          en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dph_q <= '0;
      dpl_q <= '0;
      hp_q  <= '0;
      lp_q  <= '0;
    end else if (en) begin
      dph_q <= dph_d;
      dpl_q <= dpl_d;
      hp_q  <= hp_d;
      lp_q  <= lp_d;
    end
  end

  // R8: step-up wraps inside the low nibble, high nibble untouched
  a_r8_incl_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_INCL) |=> (dpl_q == NW'($past(dpl_q) + 1'b1)) && $stable(dph_q));
  // R5: exchange-down decrements only the low nibble
  a_r5_xchd_step: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_XCHD) |=> (dpl_q == NW'($past(dpl_q) - 1'b1)) && $stable(dph_q));
  // R6: exchange-flip changes only the three low bits of the high nibble
  a_r6_xchm_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_XCHM) |=> ((dph_q ^ $past(dph_q)) == {1'b0, $past(imm[NW-2:0])}) && $stable(dpl_q));
  // R7: high-load keeps the low nibble
  a_r7_lhi_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LHI) |=> (dph_q == $past(imm)) && $stable(dpl_q));
  // R12: idle leaves the pointer alone
  a_r12_idle_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NOP) |=> $stable(dph_q) && $stable(dpl_q));
endmodule

// File: rtl/dpx_wreg.sv
module dpx_wreg
  import dpx_pkg::*;
#(
  parameter int NW   = 4,
  parameter int NREG = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op,
  input  logic [NW-1:0] imm,
  input  logic [NW-1:0] acc,
  output logic [NW-1:0] rd
);
  localparam int SW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [NREG-1:0][NW-1:0] a_q, a_d;
  logic [SW-1:0]           sel;
  logic                    we;

  assign sel = imm[SW-1:0];
  assign we  = (op == OP_XAW);
  assign rd  = a_q[sel];

  always_comb begin
    a_d      = a_q;
    a_d[sel] = acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  a_q <= '0;
    else if (we) a_q <= a_d;
  end

  // R10: scratch registers hold unless a scratch exchange is issued
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_XAW) |=> $stable(a_q));
endmodule

// File: rtl/dpx_ram.sv
module dpx_ram #(
  parameter int NW = 4,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [NW-1:0] wdata,
  output logic [NW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [NW-1:0] mem [DEPTH];

  assign rdata = mem[addr];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end
endmodule

// File: rtl/dpx_unit.sv
module dpx_unit
  import dpx_pkg::*;
#(
  parameter int NW    = 4,
  parameter int NREG  = 4,
  parameter int NPAIR = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op_i,
  input  logic [NW-1:0] imm_i,
  input  logic [NW-1:0] acc_i,
  output logic [NW-1:0] acc_o,
  output logic          zf_o,
  output logic          zf_we_o
);
  localparam int AW = 2 * NW;

  op_e           op;
  logic [NW-1:0] dph_q, dpl_q, dph_d, dpl_d;
  logic [NW-1:0] ram_rd, wreg_rd;
  logic          ram_we;

  assign op = op_e'(op_i);

  dpx_ptr #(.NW(NW), .NPAIR(NPAIR)) u_ptr (
    .clk, .rst_n, .op, .imm(imm_i), .acc(acc_i),
    .dph_q, .dpl_q, .dph_d, .dpl_d
  );

  dpx_wreg #(.NW(NW), .NREG(NREG)) u_wreg (
    .clk, .rst_n, .op, .imm(imm_i), .acc(acc_i), .rd(wreg_rd)
  );

  dpx_ram #(.NW(NW), .AW(AW)) u_ram (
    .clk, .we(ram_we), .addr({dph_q, dpl_q}), .wdata(acc_i), .rdata(ram_rd)
  );

  always_comb begin
    acc_o   = acc_i;
    zf_o    = 1'b0;
    zf_we_o = 1'b0;
    ram_we  = 1'b0;
    unique case (op)
      OP_LD:   begin acc_o = ram_rd; zf_we_o = 1'b1; zf_o = (ram_rd == '0); end
      OP_ST:   ram_we = 1'b1;
      OP_XCH:  begin acc_o = ram_rd; ram_we = 1'b1; zf_we_o = 1'b1; zf_o = (ram_rd == '0); end
      OP_XCHI, OP_XCHD:
               begin acc_o = ram_rd; ram_we = 1'b1; zf_we_o = 1'b1; zf_o = (dpl_d == '0); end
      OP_XCHM: begin acc_o = ram_rd; ram_we = 1'b1; zf_we_o = 1'b1; zf_o = (dph_d == '0); end
      OP_INCL, OP_DECL:
               begin zf_we_o = 1'b1; zf_o = (dpl_d == '0); end
      OP_TLA:  begin acc_o = dpl_q; zf_we_o = 1'b1; zf_o = (dpl_q == '0); end
      OP_XAW:  acc_o = wreg_rd;
      default: ;
    endcase
  end

  // R3: every exchange hands back the word the pointer addressed
  a_r3_xch_data: assert property (@(posedge clk) disable iff (!rst_n)
    (op inside {OP_XCH, OP_XCHI, OP_XCHD, OP_XCHM}) |-> (acc_o == ram_rd));
  // R9: transfer out of the low nibble returns the pointer itself
  a_r9_tla_value: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_TLA) |-> (acc_o == dpl_q) && zf_we_o);
endmodule

// File: tb/dpx_unit_test.sv
module dpx_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_i = '0, imm_i = '0, acc_i = '0;
  logic [3:0] acc_o;
  logic       zf_o, zf_we_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;

  dpx_unit uut (.clk, .rst_n, .op_i, .imm_i, .acc_i, .acc_o, .zf_o, .zf_we_o);

  always #2 clk = ~clk;

  // fields: req, op, imm, acc, expected acc, expected zf, expected zf strobe
  localparam int NV = 40;
  localparam logic [21:0] VEC [NV] = '{
    {4'd7,  4'h7, 4'h5, 4'h0, 4'h0, 1'b0, 1'b0}, // R7 zero-load dpl=5
    {4'd2,  4'h2, 4'h0, 4'h9, 4'h9, 1'b0, 1'b0}, // R2 store 9 @05
    {4'd2,  4'h1, 4'h0, 4'h0, 4'h9, 1'b0, 1'b1}, // R2 load
    {4'd4,  4'h4, 4'h0, 4'h3, 4'h9, 1'b0, 1'b1}, // R4 exchange-up, dpl=6
    {4'd2,  4'h2, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0}, // R2 store 0 @06
    {4'd8,  4'hA, 4'h0, 4'h7, 4'h7, 1'b0, 1'b1}, // R8 step-down, dpl=5
    {4'd4,  4'h1, 4'h0, 4'h0, 4'h3, 1'b0, 1'b1}, // R4 old acc stored
    {4'd7,  4'h7, 4'h0, 4'h2, 4'h2, 1'b0, 1'b0}, // R7 zero-load dpl=0
    {4'd8,  4'hA, 4'h0, 4'h0, 4'h0, 1'b0, 1'b1}, // R8 0 -> F
    {4'd8,  4'h9, 4'h0, 4'h0, 4'h0, 1'b1, 1'b1}, // R8 F -> 0
    {4'd9,  4'hC, 4'h0, 4'h5, 4'h0, 1'b1, 1'b1}, // R9 low-to-acc
    {4'd7,  4'h8, 4'h3, 4'h1, 4'h1, 1'b0, 1'b0}, // R7 high-load 3
    {4'd2,  4'h2, 4'h0, 4'hC, 4'hC, 1'b0, 1'b0}, // R2 store C @30
    {4'd6,  4'h6, 4'h3, 4'h6, 4'hC, 1'b1, 1'b1}, // R6 flip -> dph 0
    {4'd2,  4'h2, 4'h0, 4'hA, 4'hA, 1'b0, 1'b0}, // R2 store A @00
    {4'd6,  4'h6, 4'h3, 4'h0, 4'hA, 1'b0, 1'b1}, // R6 flip -> dph 3
    {4'd6,  4'h1, 4'h0, 4'h0, 4'h6, 1'b0, 1'b1}, // R6 load @30
    {4'd6,  4'h6, 4'hB, 4'h6, 4'h6, 1'b1, 1'b1}, // R6 bit3 ignored
    {4'd5,  4'h5, 4'h0, 4'h4, 4'h0, 1'b0, 1'b1}, // R5 exchange-down
    {4'd9,  4'hB, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0}, // R9 acc-to-low 0
    {4'd5,  4'h1, 4'h0, 4'h9, 4'h4, 1'b0, 1'b1}, // R5 no borrow to dph
    {4'd3,  4'h3, 4'h0, 4'h0, 4'h4, 1'b0, 1'b1}, // R3 exchange
    {4'd3,  4'h3, 4'h0, 4'h7, 4'h0, 1'b1, 1'b1}, // R3 zf from new acc
    {4'd10, 4'hD, 4'h2, 4'h5, 4'h0, 1'b0, 1'b0}, // R10 A2
    {4'd10, 4'hD, 4'h1, 4'h8, 4'h0, 1'b0, 1'b0}, // R10 A1
    {4'd10, 4'hD, 4'h2, 4'h3, 4'h5, 1'b0, 1'b0}, // R10 A2 back
    {4'd10, 4'hD, 4'h1, 4'h0, 4'h8, 1'b0, 1'b0}, // R10 A1 back
    {4'd7,  4'h8, 4'h7, 4'h0, 4'h0, 1'b0, 1'b0}, // R7 high-load 7
    {4'd2,  4'h2, 4'h0, 4'hD, 4'hD, 1'b0, 1'b0}, // R2 store D @70
    {4'd11, 4'hE, 4'h1, 4'h0, 4'h0, 1'b0, 1'b0}, // R11 dph<->H1
    {4'd11, 4'h1, 4'h0, 4'h0, 4'h7, 1'b0, 1'b1}, // R11 now @00
    {4'd11, 4'hE, 4'h1, 4'h0, 4'h0, 1'b0, 1'b0}, // R11 swap back
    {4'd11, 4'h1, 4'h0, 4'h0, 4'hD, 1'b0, 1'b1}, // R11 @70 again
    {4'd9,  4'hB, 4'h0, 4'h9, 4'h9, 1'b0, 1'b0}, // R9 acc-to-low 9
    {4'd11, 4'hF, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0}, // R11 dpl<->L0
    {4'd11, 4'hC, 4'h0, 4'h0, 4'h0, 1'b1, 1'b1}, // R11 dpl now 0
    {4'd11, 4'hF, 4'h0, 4'h5, 4'h5, 1'b0, 1'b0}, // R11 swap back
    {4'd11, 4'hC, 4'h0, 4'h0, 4'h9, 1'b0, 1'b1}, // R11 dpl 9
    {4'd12, 4'h0, 4'hF, 4'hE, 4'hE, 1'b0, 1'b0}, // R12 idle
    {4'd12, 4'hC, 4'h0, 4'h0, 4'h9, 1'b0, 1'b1}  // R12 dpl unchanged
  };

  task automatic apply(input logic [3:0] op, input logic [3:0] imm,
                       input logic [3:0] acc, input logic [3:0] e_acc,
                       input logic e_zf, input logic e_zu, input string req);
    @(negedge clk);
    op_i = op; imm_i = imm; acc_i = acc;
    #1;
    n_chk++;
    if (acc_o !== e_acc || zf_we_o !== e_zu || (e_zu && zf_o !== e_zf)) begin
      n_fail++;
      $display("FAIL %s op=%h: acc=%h zf=%b zfwe=%b expected acc=%h zf=%b zfwe=%b",
               req, op, acc_o, zf_o, zf_we_o, e_acc, e_zf, e_zu);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected below 5000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    apply(4'hC, 4'h0, 4'h6, 4'h0, 1'b1, 1'b1, "R1");
    apply(4'hD, 4'h3, 4'h0, 4'h0, 1'b0, 1'b0, "R1");
    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      v = VEC[i];
      apply(v[17:14], v[13:10], v[9:6], v[5:2], v[1], v[0],
            $sformatf("R%0d", v[21:18]));
    end
    // R1 reset mid-run clears pointer and scratch registers
    @(negedge clk);
    op_i = 4'h0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    apply(4'hC, 4'h0, 4'h3, 4'h0, 1'b1, 1'b1, "R1");
    apply(4'hD, 4'h2, 4'h0, 4'h0, 1'b0, 1'b0, "R1");
    apply(4'hE, 4'h0, 4'h1, 4'h1, 1'b0, 1'b0, "R1");
    @(negedge clk);
    op_i = 4'h0;
    finish_run();
  end
endmodule